// File: doc/BRIEF.md
# I2C Register-Access Target with Per-Byte CRC-8

This block is an I2C target that lets a bus host read and write a byte-addressed register file. A transfer opens with an address byte whose upper seven bits must equal the configured target address and whose lowest bit picks the direction (0 write, 1 read). In a write, the byte after the address byte sets the register pointer, and every further byte is stored at the pointer, which then advances. A read returns bytes from the pointer onward, advancing after each byte. The pointer can be set by a write that ends in a STOP and then used by a separate read, or the read can follow a repeated START.

When the CRC-enable input is high, every data byte is followed by a CRC-8 byte in both directions. The CRC uses polynomial 0x07 and an initial value of zero, and is computed MSB first. The first CRC of a transfer also covers the bytes that came before the first data byte. On a write the data byte is held back until its CRC has been checked, so a wrong or missing CRC never reaches the register file. A wrong CRC from the host is NACKed, and a NACK from the host ends a read. In both cases the target returns to idle.

SCL and SDA are sampled on a fast system clock through a synchronizer. The target only ever pulls SDA low, through an output enable. It does not stretch the clock. A separate timeout block resets it through the synchronous reset.

Top module: `i2c_crc_target`

## Requirements
- R1: The target ACKs (pulls SDA low in the ninth clock) an address byte whose bits [7:1] equal `dev_addr`. For any other address it does not ACK, writes nothing and leaves SDA alone until the next START.
- R2: With CRC disabled, the byte after a write address byte loads the register pointer. Each later byte is ACKed and written with a single-cycle `reg_we` pulse at the pointer.
- R3: After each register write the pointer advances by one, so a block write fills consecutive registers.
- R4: After a repeated START and a read address byte, the target sends the register at the pointer, MSB first, and then the following registers while the host ACKs. A host NACK after a data byte ends the transfer.
- R5: A pointer loaded by a write that ends in STOP is still in effect for a later read transfer.
- R6: With CRC enabled, each write data byte is followed by a CRC byte (poly 0x07, init 0, MSB first). The first CRC covers the write address byte, the pointer byte and the first data byte, and each later CRC covers its own data byte only. When the CRC matches, the target ACKs it and commits the data.
- R7: On a CRC mismatch the target NACKs the CRC byte, does not write that data byte, and ignores every byte that follows until the next START.
- R8: With CRC enabled, a data byte whose CRC never arrives before STOP is not written.
- R9: With CRC enabled, in a read the target sends a CRC byte after each data byte. The first CRC covers the read address byte and the first data byte, and each later CRC covers its own data byte only. A host NACK on a CRC byte returns the target to idle.
- R10: The target starts driving SDA only while SCL is low, and it has released SDA one cycle after a STOP.
- R11: Reset leaves SDA released and `reg_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset (also driven by the bus timeout block) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low |
| dev_addr | input | 7 | Target address |
| crc_en | input | 1 | Enables the per-byte CRC-8 |
| reg_addr | output | REG_AW | Register pointer, used for both read and write |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data at `reg_addr`, valid within a few clocks of a pointer change |

## Verification
A wrong pointer or a wrong byte-phase count shows at the ports within one byte time. The host then sees a misplaced ACK, or a data or CRC byte that differs from the model, and the shadow register file no longer matches the expected contents. If the CRC accumulator is cleared in the wrong place, the first or a later CRC byte comes out wrong on reads, or a good CRC is NACKed on writes, at the first CRC-bearing byte. If a commit leaks past a bad or missing CRC, the register file differs at the end of that same transfer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_t;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_PTR,
    RL_DATA,
    RL_CRC
  } byte_role_t;

  function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] acc,
                                                   input logic [BYTE_W-1:0] din);
    logic [BYTE_W-1:0] c;
    c = acc ^ din;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[BYTE_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-1:0], raw[g]};
    end
    assign cur[g]  = chain[STAGES-1];
    assign prev[g] = chain[STAGES];
  end

endmodule

// File: rtl/i2c_crc8_acc.sv
module i2c_crc8_acc
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              feed,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || (clr && !feed)) crc <= '0;
    else if (feed)             crc <= crc8_step(clr ? '0 : crc, din);
  end

endmodule

// File: rtl/i2c_crc_target.sv
module i2c_crc_target
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [6:0]        dev_addr,
  input  logic              crc_en,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  input  logic [7:0]        reg_rdata
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [1:0] pin_cur, pin_prev;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  i2c_pin_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst(rst), .raw({scl_i, sda_i}), .cur(pin_cur), .prev(pin_prev)
  );

  assign {scl_s, sda_s} = pin_cur;
  assign {scl_p, sda_p} = pin_prev;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

  tgt_state_t        st;
  byte_role_t        role;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, pend_d, rx_byte, crc_val, crc_din;
  logic              rw, phase, ackval, pend_v;
  logic              addr_hit, rx_done, ack_end, hack_end, load_rd, load_crc;
  logic              crc_clr, crc_feed;

  assign rx_byte  = {shreg[BYTE_W-2:0], sda_s};
  assign addr_hit = (rx_byte[7:1] == dev_addr);
  assign rx_done  = (st == ST_RX) && scl_rise && (bitcnt == LAST_BIT);
  assign ack_end  = (st == ST_RX_ACK) && scl_fall && phase;
  assign hack_end = (st == ST_TX_ACK) && scl_fall && phase;
  assign load_crc = hack_end && (role == RL_DATA) && crc_en;
  assign load_rd  = (ack_end && ackval && (role == RL_ADDR) && rw) ||
                    (hack_end && !((role == RL_DATA) && crc_en));

  // CRC scope: everything since START or since the last CRC byte.
  always_comb begin
    crc_clr  = 1'b0;
    crc_feed = 1'b0;
    crc_din  = rx_byte;
    if (start_evt) begin
      crc_clr = 1'b1;
    end else if (rx_done) begin
      if (role == RL_CRC)                   crc_clr  = 1'b1;
      else if (role != RL_ADDR || addr_hit) crc_feed = 1'b1;
    end else if (load_crc) begin
      crc_clr = 1'b1;
    end else if (load_rd) begin
      crc_feed = 1'b1;
      crc_din  = reg_rdata;
    end
  end

  i2c_crc8_acc u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .feed(crc_feed), .din(crc_din), .crc(crc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      role      <= RL_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      pend_d    <= '0;
      pend_v    <= 1'b0;
      rw        <= 1'b0;
      phase     <= 1'b0;
      ackval    <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) reg_addr <= reg_addr + REG_AW'(1);
      if (start_evt) begin
        st     <= ST_RX;
        role   <= RL_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        pend_v <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        pend_v <= 1'b0;
      end else begin
        case (st)
          ST_RX: if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + CNT_W'(1);
            if (bitcnt == LAST_BIT) begin
              st     <= ST_RX_ACK;
              phase  <= 1'b0;
              ackval <= 1'b1;
              case (role)
                RL_ADDR: if (!addr_hit) st <= ST_IDLE;
                         else           rw <= rx_byte[0];
                RL_PTR:  reg_addr <= REG_AW'(rx_byte);
                RL_DATA: if (crc_en) begin
                  pend_d <= rx_byte;
                  pend_v <= 1'b1;
                end else begin
                  reg_wdata <= rx_byte;
                  reg_we    <= 1'b1;
                end
                default: begin
                  if (pend_v && rx_byte == crc_val) begin
                    reg_wdata <= pend_d;
                    reg_we    <= 1'b1;
                  end else begin
                    ackval <= 1'b0;
                  end
                  pend_v <= 1'b0;
                end
              endcase
            end
          end
          ST_RX_ACK: if (scl_fall) begin
            if (!phase) begin
              phase  <= 1'b1;
              sda_oe <= ackval;
            end else begin
              phase  <= 1'b0;
              bitcnt <= '0;
              sda_oe <= 1'b0;
              if (!ackval) begin
                st <= ST_IDLE;
              end else if (role == RL_ADDR && rw) begin
                st     <= ST_TX;
                role   <= RL_DATA;
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
              end else begin
                st <= ST_RX;
                case (role)
                  RL_ADDR: role <= RL_PTR;
                  RL_DATA: role <= crc_en ? RL_CRC : RL_DATA;
                  default: role <= RL_DATA;
                endcase
              end
            end
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              st     <= ST_TX_ACK;
              phase  <= 1'b0;
              bitcnt <= '0;
              if (role == RL_DATA) reg_addr <= reg_addr + REG_AW'(1);
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
              bitcnt <= bitcnt + CNT_W'(1);
            end
          end
          ST_TX_ACK: begin
            if (scl_rise && !phase) begin
              if (sda_s) st    <= ST_IDLE;
              else       phase <= 1'b1;
            end else if (hack_end) begin
              phase  <= 1'b0;
              bitcnt <= '0;
              st     <= ST_TX;
              if (load_crc) begin
                role   <= RL_CRC;
                shreg  <= crc_val;
                sda_oe <= ~crc_val[7];
              end else begin
                role   <= RL_DATA;
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: SDA is only pulled low in response to an SCL falling edge
  a_r10_drive_on_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  // R10: bus released right after STOP
  a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);
  // R1: an idle target never drives the bus
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);
  // R2: write strobe is a single cycle
  a_r2_we_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  // R3: pointer advances after each write
  a_r3_ptr_inc: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == $past(reg_addr) + REG_AW'(1)));
  // R11: quiet outputs on leaving reset
  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && !reg_we));

endmodule

// File: tb/test_i2c_crc_target.sv
module test_i2c_crc_target;

  localparam int Q = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       scl_h = 1'b1, sda_h = 1'b1;
  logic       sda_oe, crc_en = 1'b0, reg_we;
  logic [6:0] dev = 7'h08;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_line;

  assign sda_line = sda_h & ~sda_oe;

  i2c_crc_target i_i2c_crc_target (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_addr(dev), .crc_en(crc_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  logic [7:0] mem   [256];
  logic [7:0] model [256];
  logic [7:0] wbuf  [8];

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  int ntests = 0, nfail = 0, viol = 0;
  logic oe_d = 1'b0;

  always @(negedge clk) begin
    if (sda_oe && !oe_d && scl_h) viol++;
    oe_d = sda_oe;
  end

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int k = 0; k < 8; k++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_start;
    sda_h = 1'b1; wt(Q); scl_h = 1'b1; wt(Q); sda_h = 1'b0; wt(Q); scl_h = 1'b0; wt(Q);
  endtask

  task automatic h_stop;
    sda_h = 1'b0; wt(Q); scl_h = 1'b1; wt(Q); sda_h = 1'b1; wt(Q);
  endtask

  task automatic h_wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wt(Q); scl_h = 1'b1; wt(2 * Q); scl_h = 1'b0; wt(Q);
    end
    sda_h = 1'b1; wt(Q); scl_h = 1'b1; wt(Q);
    ack = ~sda_line;
    wt(Q); scl_h = 1'b0; wt(Q);
  endtask

  task automatic h_rd(input logic ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_h = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl_h = 1'b0; wt(Q);
    end
    sda_h = ~ack; wt(Q); scl_h = 1'b1; wt(2 * Q); scl_h = 1'b0; wt(Q);
    sda_h = 1'b1;
  endtask

  task automatic check_mem(input string tag);
    int mism = 0;
    wt(4);
    for (int i = 0; i < 256; i++) if (mem[i] !== model[i]) mism++;
    chk(tag, mism, 0);
  endtask

  // Write transfer; bad_at: data index whose CRC is corrupted (-1 none);
  // cut: stop before the last CRC byte.
  task automatic wr_txn(input logic [7:0] r, input int n, input logic use_crc,
                        input int bad_at, input logic cut);
    logic a, alive;
    logic [7:0] c, ptr;
    alive = 1'b1;
    ptr = r;
    h_start;
    h_wr({dev, 1'b0}, a); chk("R1 address ACK", a, 1);
    h_wr(r, a);           chk("R2 pointer ACK", a, 1);
    c = crc_upd(crc_upd(8'h00, {dev, 1'b0}), r);
    for (int i = 0; i < n; i++) begin
      h_wr(wbuf[i], a);
      if (alive) chk("R2 data ACK", a, 1);
      else       chk("R7 byte after bad CRC ignored", a, 0);
      if (alive) begin
        if (use_crc) begin
          c = crc_upd((i == 0) ? c : 8'h00, wbuf[i]);
          if (!(cut && i == n - 1)) begin
            if (i == bad_at) begin
              h_wr(c ^ 8'h5A, a); chk("R7 bad CRC NACK", a, 0);
              alive = 1'b0;
            end else begin
              h_wr(c, a); chk("R6 good CRC ACK", a, 1);
              model[ptr] = wbuf[i];
              ptr++;
            end
          end
        end else begin
          model[ptr] = wbuf[i];
          ptr++;
        end
      end
    end
    h_stop;
  endtask

  task automatic rd_txn(input logic [7:0] r, input int n, input logic use_crc,
                        input logic rep);
    logic a;
    logic [7:0] c, b, ptr;
    ptr = r;
    h_start;
    h_wr({dev, 1'b0}, a); chk("R1 address ACK", a, 1);
    h_wr(r, a);           chk("R5 pointer ACK", a, 1);
    if (!rep) h_stop;
    h_start;
    h_wr({dev, 1'b1}, a); chk("R4 read address ACK", a, 1);
    c = crc_upd(8'h00, {dev, 1'b1});
    for (int i = 0; i < n; i++) begin
      if (use_crc) begin
        h_rd(1'b1, b); chk("R9 read data", b, model[ptr]);
        c = crc_upd((i == 0) ? c : 8'h00, model[ptr]);
        h_rd(i != n - 1, b); chk("R9 read CRC", b, c);
      end else begin
        h_rd(i != n - 1, b);
        chk(rep ? "R4 read data" : "R5 read data after STOP", b, model[ptr]);
      end
      ptr++;
    end
    h_stop;
    wt(2);
    chk("R10 SDA released after read", sda_oe, 0);
  endtask

  initial begin
    logic a;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) model[i] = init_val(i);
    wt(5);
    rst = 1'b0;
    wt(1);
    chk("R11 reset sda_oe", sda_oe, 0);
    chk("R11 reset reg_we", reg_we, 0);

    // R1: foreign address is ignored until the next START
    h_start;
    h_wr({dev ^ 7'h15, 1'b0}, a); chk("R1 foreign address NACK", a, 0);
    h_wr(8'h20, a);               chk("R1 ignored pointer", a, 0);
    h_wr(8'hEE, a);               chk("R1 ignored data", a, 0);
    h_stop;
    check_mem("R1 no write on foreign address");

    // R2/R3: block write across the pointer wrap
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'hA0 + i);
    wr_txn(8'hFE, 4, 1'b0, -1, 1'b0);
    check_mem("R3 block write contents");
    rd_txn(8'hFE, 4, 1'b0, 1'b1);
    rd_txn(8'h10, 3, 1'b0, 1'b0);

    // R1: configurable address
    dev = 7'h51;
    wbuf[0] = 8'h3C;
    wr_txn(8'h40, 1, 1'b0, -1, 1'b0);
    check_mem("R1 new address accepted");
    dev = 7'h08;

    // R6..R9 with CRC
    crc_en = 1'b1;
    for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'h5B * (i + 1));
    wr_txn(8'h30, 3, 1'b1, -1, 1'b0);
    check_mem("R6 CRC write contents");
    for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'hC1 + i);
    wr_txn(8'h30, 3, 1'b1, 1, 1'b0);
    check_mem("R7 nothing after bad CRC committed");
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    wr_txn(8'h50, 2, 1'b1, -1, 1'b1);
    check_mem("R8 uncovered byte not written");
    rd_txn(8'h30, 3, 1'b1, 1'b1);
    rd_txn(8'h50, 2, 1'b1, 1'b0);

    // constrained random mix
    for (int it = 0; it < 14; it++) begin
      logic [7:0] r;
      int n;
      crc_en = 1'($urandom % 2);
      r = 8'($urandom);
      n = 1 + int'($urandom % 4);
      if ($urandom % 2 == 0) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        wr_txn(r, n, crc_en, -1, 1'b0);
        check_mem("R3 random write contents");
      end else begin
        rd_txn(r, n, crc_en, 1'($urandom % 2));
      end
    end

    chk("R10 SDA only driven while SCL low", viol, 0);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    ntests++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule